// File: doc/BRIEF.md
# External-Clock Conversion Frame Sequencer

This block produces the device-side timing of one analog-to-digital conversion when the host's serial clock also steps the successive-approximation search. A command decoder issues a one-cycle `go` pulse once it has taken in the start bit. The pulse carries the frame length (short, 24 serial clocks, or long, 32) and the output coding (unipolar or bipolar). After that the sequencer counts serial-clock falling edges. The bench or the surrounding logic supplies each edge as a one-cycle `sclkFall` pulse, synchronous to `clk`.

The sequencer opens an acquisition window, raises a strobe for one serial-clock period just before the most significant result bit, and then shifts the 14-bit result out one bit per falling edge, MSB first. After the LSB it pads with zeros until the frame ends. A behavioural result code arrives on `result` and is taken when acquisition closes. While chip select is high, counted edges and new commands have no effect and both serial outputs are released. The two enable outputs show that release in place of real tri-state pins.

Top module: `ext_clk_frame_seq`

## Requirements
- R1: After reset, `dout`, `strobe` and `acqActive` are 0 and no frame is active.
- R2: In a short frame (`goLong`=0), `strobe` is 1 from the 7th counted falling edge after `go` until the 8th, and 0 at all other times.
- R3: In a long frame (`goLong`=1), `strobe` is 1 from the 15th counted falling edge until the 16th, and 0 at all other times.
- R4: `acqActive` rises with an accepted `go` and falls on the 6th counted falling edge (short frame) or the 14th (long frame).
- R5: The result MSB appears on `dout` at falling edge 8 (short) or 16 (long). Each later edge presents the next bit. After the LSB, `dout` is 0 through the frame's last edge (24 or 32) and stays 0 while idle.
- R6: With `goBip`=0 the code on `result` is sent unchanged, as straight binary. With `goBip`=1 `result` is read as offset binary, and its bit 13 is inverted so that the output is two's complement.
- R7: `doutEn` and `strobeEn` are both equal to the inverse of `csN` on every cycle.
- R8: A `sclkFall` pulse while `csN`=1 is not counted. The frame resumes at the same count once `csN` returns to 0.
- R9: A `go` pulse while `csN`=1 is ignored and starts no frame.
- R10: A `go` accepted during an active frame abandons that frame and restarts counting from zero with the new modes.
- R11: The result code is sampled on the falling edge that closes acquisition. Later changes on `result` do not alter the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclkFall | input | 1 | One-cycle pulse marking a serial-clock falling edge |
| go | input | 1 | One-cycle pulse: start bit received, begin a frame |
| goLong | input | 1 | Frame length with `go`: 1 = 32 clocks, 0 = 24 clocks |
| goBip | input | 1 | Coding with `go`: 1 = bipolar (two's complement), 0 = unipolar |
| result | input | 14 | Behavioural conversion code (offset binary) |
| dout | output | 1 | Serial result bit |
| doutEn | output | 1 | Drive enable for `dout` |
| strobe | output | 1 | Pulse one serial period ahead of the MSB |
| strobeEn | output | 1 | Drive enable for `strobe` |
| acqActive | output | 1 | Acquisition window in progress |

## Verification
On every cycle the assertions check that the strobe never overlaps the acquisition window and lasts exactly one counted edge. They check that a raised chip select freezes the edge count and frame state, that the result is loaded while the window is still open, and that the data line carries zeros once all result bits have left. Other behaviours can only be shown by the bench's scenarios, which it compares cycle by cycle against its reference model: the exact edge numbers for the strobe, the window and the MSB in both frame lengths, the bipolar code conversion, resuming after a pause, ignoring a command while deselected, restarting during a frame, and immunity of the result to late changes.

// File: rtl/efs_pkg.sv
package efs_pkg;
  // Strobes issued by the control path to the data path.
  typedef struct packed {
    logic clear;  // frame (re)started: idle the data line
    logic load;   // acquisition closes: capture the result
    logic shift;  // counted edge in the output slots
    logic bip;    // bipolar coding for the capture
  } efsCtl_t;
endpackage

// File: rtl/efs_ctrl.sv
module efs_ctrl
  import efs_pkg::*;
#(
  parameter int SHORT_LEN = 24,
  parameter int LONG_LEN  = 32,
  parameter int SHORT_ACQ = 6,
  parameter int LONG_ACQ  = 14,
  parameter int CW        = $clog2(LONG_LEN + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclkFall,
  input  logic    go,
  input  logic    goLong,
  input  logic    goBip,
  output efsCtl_t ctl,
  output logic    strobe,
  output logic    acqActive
);
  localparam logic [CW-1:0] S_LEN = CW'(SHORT_LEN);
  localparam logic [CW-1:0] L_LEN = CW'(LONG_LEN);
  localparam logic [CW-1:0] S_ACQ = CW'(SHORT_ACQ);
  localparam logic [CW-1:0] L_ACQ = CW'(LONG_ACQ);

  logic          active;
  logic          longMode;
  logic          bipMode;
  logic [CW-1:0] fallCnt;
  logic [CW-1:0] cntNext;
  logic [CW-1:0] acqEnd;
  logic [CW-1:0] strobeAt;
  logic [CW-1:0] msbAt;
  logic [CW-1:0] frameEnd;
  logic          goTake;
  logic          countedFall;

  assign goTake      = go && !csN;
  assign countedFall = active && sclkFall && !csN && !goTake;
  assign cntNext     = fallCnt + 1'b1;
  assign acqEnd      = longMode ? L_ACQ : S_ACQ;
  assign strobeAt    = acqEnd + CW'(1);
  assign msbAt       = acqEnd + CW'(2);
  assign frameEnd    = longMode ? L_LEN : S_LEN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      longMode <= 1'b0;
      bipMode  <= 1'b0;
      fallCnt  <= '0;
    end else if (goTake) begin
      active   <= 1'b1;
      longMode <= goLong;
      bipMode  <= goBip;
      fallCnt  <= '0;
    end else if (countedFall) begin
      if (cntNext == frameEnd) begin
        active  <= 1'b0;
        fallCnt <= '0;
      end else begin
        fallCnt <= cntNext;
      end
    end
  end

  always_comb begin
    ctl.clear = goTake;
    ctl.load  = countedFall && (cntNext == acqEnd);
    ctl.shift = countedFall && (cntNext >= msbAt);
    ctl.bip   = bipMode;
  end

  assign strobe    = active && (fallCnt == strobeAt);
  assign acqActive = active && (fallCnt < acqEnd);

  assert_strobe_outside_acq_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> !acqActive);

  assert_strobe_one_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && countedFall) |=> !strobe);

  assert_pause_freezes_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> ($stable(fallCnt) && $stable(active)));

  assert_load_in_window_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> acqActive);
endmodule

// File: rtl/efs_datapath.sv
module efs_datapath
  import efs_pkg::*;
#(
  parameter int RES_BITS = 14,
  parameter int SW       = $clog2(RES_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  efsCtl_t             ctl,
  input  logic [RES_BITS-1:0] result,
  output logic                dout
);
  localparam logic [SW-1:0] FULL = SW'(RES_BITS);

  logic [RES_BITS-1:0] coded;
  logic [RES_BITS-1:0] shiftReg;
  logic                doutReg;

  generate
    if (RES_BITS > 1) begin : g_wide
      assign coded = ctl.bip ? {~result[RES_BITS-1], result[RES_BITS-2:0]} : result;
    end else begin : g_narrow
      assign coded = ctl.bip ? ~result : result;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      doutReg  <= 1'b0;
    end else if (ctl.clear) begin
      shiftReg <= '0;
      doutReg  <= 1'b0;
    end else if (ctl.load) begin
      shiftReg <= coded;
    end else if (ctl.shift) begin
      doutReg  <= shiftReg[RES_BITS-1];
      shiftReg <= shiftReg << 1;
    end
  end

  assign dout = doutReg;

  // Checker-side count of bits sent since the last capture.
  logic [SW-1:0] sentCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             sentCnt <= FULL;
    else if (ctl.clear)                    sentCnt <= FULL;
    else if (ctl.load)                     sentCnt <= '0;
    else if (ctl.shift && sentCnt != FULL) sentCnt <= sentCnt + 1'b1;
  end

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && !ctl.load && !ctl.clear && sentCnt == FULL) |=> !doutReg);
endmodule

// File: rtl/ext_clk_frame_seq.sv
module ext_clk_frame_seq
  import efs_pkg::*;
#(
  parameter int RES_BITS  = 14,
  parameter int SHORT_LEN = 24,
  parameter int LONG_LEN  = 32,
  parameter int SHORT_ACQ = 6,
  parameter int LONG_ACQ  = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclkFall,
  input  logic                go,
  input  logic                goLong,
  input  logic                goBip,
  input  logic [RES_BITS-1:0] result,
  output logic                dout,
  output logic                doutEn,
  output logic                strobe,
  output logic                strobeEn,
  output logic                acqActive
);
  efsCtl_t ctl;

  efs_ctrl #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
    .SHORT_ACQ(SHORT_ACQ), .LONG_ACQ(LONG_ACQ)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclkFall(sclkFall),
    .go(go), .goLong(goLong), .goBip(goBip),
    .ctl(ctl), .strobe(strobe), .acqActive(acqActive)
  );

  efs_datapath #(.RES_BITS(RES_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .result(result), .dout(dout)
  );

  assign doutEn   = !csN;
  assign strobeEn = !csN;
endmodule

// File: tb/ext_clk_frame_seq_tb_top.sv
`timescale 1ns/1ps
module ext_clk_frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclkFall = 1'b0;
  logic        go = 1'b0;
  logic        goLong = 1'b0;
  logic        goBip = 1'b0;
  logic [13:0] result = '0;
  logic        dout, doutEn, strobe, strobeEn, acqActive;

  always #4 clk = ~clk;

  ext_clk_frame_seq dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclkFall(sclkFall), .go(go),
    .goLong(goLong), .goBip(goBip), .result(result), .dout(dout),
    .doutEn(doutEn), .strobe(strobe), .strobeEn(strobeEn), .acqActive(acqActive)
  );

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  // stimulus intent
  logic        tbCs = 1'b1, tbLong = 1'b0, tbBip = 1'b0;
  logic [13:0] tbRes = '0;

  // reference model state
  bit     mActive = 0, mLong = 0, mBip = 0, mDout = 0, mCs = 1;
  int     mCnt = 0;
  bit     mQ[$];

  task automatic chk(input string sig, input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s actual=%0b expected=%0b at %0t", req, curTag, sig, act, exp, $time);
    end
  endtask

  task automatic step(input logic g, input logic f);
    int acqN, strN, msbN, lenN;
    logic [13:0] code;
    @(negedge clk);
    acqN = mLong ? 14 : 6;
    chk("dout", "R5", dout, mDout);
    chk("strobe", mLong ? "R3" : "R2", strobe, mActive && mCnt == acqN + 1);
    chk("acqActive", "R4", acqActive, mActive && mCnt < acqN);
    chk("doutEn", "R7", doutEn, !mCs);
    chk("strobeEn", "R7", strobeEn, !mCs);
    go = g; sclkFall = f; csN = tbCs; result = tbRes; goLong = tbLong; goBip = tbBip;
    if (g && !tbCs) begin
      mActive = 1; mCnt = 0; mLong = tbLong; mBip = tbBip; mDout = 0;
      mQ.delete();
    end else if (mActive && f && !tbCs) begin
      acqN = mLong ? 14 : 6;
      strN = acqN + 1;
      msbN = acqN + 2;
      lenN = mLong ? 32 : 24;
      mCnt++;
      if (mCnt == acqN) begin
        code = mBip ? (tbRes ^ 14'h2000) : tbRes;
        mQ.delete();
        for (int i = 13; i >= 0; i--) mQ.push_back(code[i]);
      end
      if (mCnt >= msbN) mDout = (mQ.size() > 0) ? mQ.pop_front() : 1'b0;
      if (mCnt == lenN) begin mActive = 0; mCnt = 0; end
      if (strN < 0) mDout = 0;
    end
    mCs = tbCs;
  endtask

  task automatic falls(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
    end
  endtask

  task automatic startFrame(input logic lng, input logic bip, input logic [13:0] code);
    tbLong = lng; tbBip = bip; tbRes = code;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curTag = "R1";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

    curTag = "R2";  // short unipolar frame
    tbCs = 1'b0;
    startFrame(1'b0, 1'b0, 14'h2A5C);
    falls(24);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);

    curTag = "R3/R6";  // long bipolar frame
    startFrame(1'b1, 1'b1, 14'h0123);
    falls(32);

    curTag = "R6";  // short bipolar, full-scale code
    startFrame(1'b0, 1'b1, 14'h3FFF);
    falls(24);

    curTag = "R8";  // pause mid-conversion
    startFrame(1'b0, 1'b0, 14'h1B3D);
    falls(10);
    tbCs = 1'b1;
    falls(3);
    tbCs = 1'b0;
    falls(14);

    curTag = "R9";  // command while deselected
    tbCs = 1'b1;
    tbLong = 1'b0; tbRes = 14'h3333;
    step(1'b1, 1'b0);
    tbCs = 1'b0;
    falls(9);

    curTag = "R10";  // restart during long frame
    startFrame(1'b1, 1'b0, 14'h0F0F);
    falls(9);
    startFrame(1'b0, 1'b0, 14'h2222);
    falls(24);

    curTag = "R11";  // result changes after sampling
    startFrame(1'b0, 1'b0, 14'h15AA);
    falls(6);
    tbRes = 14'h0000;
    falls(18);

    curTag = "R4";  // long unipolar window
    startFrame(1'b1, 1'b0, 14'h3001);
    falls(32);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule